// File: doc/BRIEF.md
# Serial Flash Erase/Program Request Sequencer

This block sits behind a serial-peripheral slave front end that has already turned the serial line into bytes. During each chip-select frame it collects a one-byte command and then a three-byte address. For a program command it also collects the data bytes that follow. When the frame closes, it checks that the frame is well formed and issues one request to the memory back end. A request is either a program of part of a 256-byte page, an erase of a 4 KB block, or an erase of a 32 KB block.

For an erase, the block aligns the address down to the erase granularity. Program data is placed into an internal page buffer at the byte's offset within the page. The back end reads that buffer through a byte index port while it performs the program. Addresses are held to the 128 KB (1 Mbit) array range. A frame that arrives while the back end reports busy is discarded.

Top module: `flash_cmd_seq`

## Requirements
- R1: The first byte of a frame is the command: 02h selects program, 20h selects 4 KB erase, 52h selects 32 KB erase. `req_type_o` reports 1 for program, 2 for 4 KB erase and 3 for 32 KB erase, and 0 only after reset.
- R2: The three bytes after the command form a 24-bit address, most significant byte first. Only its low 17 bits are kept, so the range is 00000h to 1FFFFh.
- R3: A 4 KB erase request reports the address with bits 11:0 cleared and a length of 0.
- R4: A 32 KB erase request reports the address with bits 14:0 cleared and a length of 0.
- R5: An erase is issued only when its frame holds exactly four bytes. A frame with fewer or more bytes issues nothing.
- R6: A program request reports the unaligned 17-bit address and a length equal to the number of data bytes, from 1 to 256. A program frame with no data byte issues nothing.
- R7: Data byte k of a program frame (k counted from 0) is stored at page offset (address[7:0] + k) mod 256. `buf_data_o` returns the stored byte at offset `buf_idx_i`.
- R8: When more than 256 data bytes are sent, the length is 256 and the buffer holds the last 256 bytes sent.
- R9: A frame with any other command byte issues nothing and leaves the page buffer unchanged.
- R10: If `busy_i` is high in the cycle the frame closes, no request is issued.
- R11: `req_valid_o` pulses for exactly one cycle, in the cycle after the clock edge that samples `frame_i` low. `req_type_o`, `req_addr_o` and `req_len_o` hold their values until the next request is issued.
- R12: A byte presented while `frame_i` is low has no effect.
- R13: After reset, `req_valid_o`, `req_type_o`, `req_addr_o` and `req_len_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | High while chip select is asserted |
| byte_valid_i | input | 1 | Strobe: a received byte is on `byte_i` |
| byte_i | input | 8 | Received byte |
| busy_i | input | 1 | Back end cannot accept a request |
| req_valid_o | output | 1 | One-cycle request strobe |
| req_type_o | output | 2 | Request kind (1 program, 2 erase 4 KB, 3 erase 32 KB) |
| req_addr_o | output | 17 | Aligned erase base or program start address |
| req_len_o | output | 9 | Program byte count 1..256, 0 for erase |
| buf_idx_i | input | 8 | Page buffer read offset |
| buf_data_o | output | 8 | Page buffer byte at `buf_idx_i` |

## Verification
On every cycle, the assertions check the following:
- the request strobe is a single-cycle pulse that follows the closing of a frame;
- no request is issued in a cycle after `busy_i` was high;
- erase addresses carry the latched address bits above the erase granularity, with the bits below it cleared;
- program lengths stay between 1 and 256;
- the data counter never passes one full page.

Some behaviours can only be shown by the bench's scenarios, because they depend on the content of a whole frame:
- the wrap of program data within the page;
- keeping only the last 256 bytes of a long frame;
- leaving the buffer untouched for unknown commands and for bytes outside a frame;
- dropping erase frames of the wrong length.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_PROG  = 2'd1,
    REQ_ER4K  = 2'd2,
    REQ_ER32K = 2'd3
  } req_kind_e;

  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_ER4K  = 8'h20;
  localparam logic [7:0] OPC_ER32K = 8'h52;
  localparam int unsigned HDR_BYTES = 4;

  function automatic req_kind_e decode_opc(input logic [7:0] b);
    case (b)
      OPC_PROG:  return REQ_PROG;
      OPC_ER4K:  return REQ_ER4K;
      OPC_ER32K: return REQ_ER32K;
      default:   return REQ_NONE;
    endcase
  endfunction
endpackage

// File: rtl/seq_frame_rx.sv
module seq_frame_rx
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output req_kind_e         kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              hdr_done_o,
  output logic [PAGE_W:0]   data_cnt_o,
  output logic              wr_en_o,
  output logic [PAGE_W-1:0] wr_off_o,
  output logic [7:0]        wr_data_o
);
  localparam logic [PAGE_W:0] PAGE_BYTES = (PAGE_W+1)'(1 << PAGE_W);

  req_kind_e         kind_q;
  logic [2:0]        hdr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W:0]   cnt_q;
  logic [PAGE_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= REQ_NONE;
      hdr_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (!frame_i) begin
      kind_q <= REQ_NONE;
      hdr_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (byte_valid_i) begin
      if (hdr_q == 3'd0) begin
        kind_q <= decode_opc(byte_i);
        hdr_q  <= 3'd1;
      end else if (hdr_q < 3'(HDR_BYTES)) begin
        // upper address bits fall off the top of the shift
        addr_q <= {addr_q[ADDR_W-9:0], byte_i};
        hdr_q  <= hdr_q + 3'd1;
      end else begin
        if (cnt_q != PAGE_BYTES) cnt_q <= cnt_q + 1'b1;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign kind_o     = kind_q;
  assign addr_o     = addr_q;
  assign hdr_done_o = (hdr_q == 3'(HDR_BYTES));
  assign data_cnt_o = cnt_q;
  assign wr_en_o    = frame_i && byte_valid_i && hdr_done_o && (kind_q == REQ_PROG);
  assign wr_off_o   = addr_q[PAGE_W-1:0] + idx_q;
  assign wr_data_o  = byte_i;

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PAGE_BYTES);

  a_r12_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> (hdr_q == 3'd0 && cnt_q == '0));
endmodule

// File: rtl/seq_page_buf.sv
module seq_page_buf #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_off_i,
  input  logic [7:0]        wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned DEPTH = 1 << PAGE_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_off_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/seq_req_gen.sv
module seq_req_gen
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned E4_W   = 12,
  parameter int unsigned E32_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              busy_i,
  input  req_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hdr_done_i,
  input  logic [PAGE_W:0]   data_cnt_i,
  output logic              req_valid_o,
  output req_kind_e         req_kind_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [PAGE_W:0]   req_len_o
);
  localparam logic [ADDR_W-1:0] MASK4  = ~((ADDR_W)'((1 << E4_W) - 1));
  localparam logic [ADDR_W-1:0] MASK32 = ~((ADDR_W)'((1 << E32_W) - 1));
  localparam logic [PAGE_W:0]   PAGE_BYTES = (PAGE_W+1)'(1 << PAGE_W);

  logic frame_q;
  logic frame_end, accept;
  logic [ADDR_W-1:0] base;

  assign frame_end = frame_q && !frame_i;

  always_comb begin
    accept = 1'b0;
    base   = addr_i;
    unique case (kind_i)
      REQ_PROG:  accept = data_cnt_i != '0;
      REQ_ER4K:  begin accept = data_cnt_i == '0; base = addr_i & MASK4;  end
      REQ_ER32K: begin accept = data_cnt_i == '0; base = addr_i & MASK32; end
      default:   accept = 1'b0;
    endcase
    accept = accept && hdr_done_i && !busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q     <= 1'b0;
      req_valid_o <= 1'b0;
      req_kind_o  <= REQ_NONE;
      req_addr_o  <= '0;
      req_len_o   <= '0;
    end else begin
      frame_q     <= frame_i;
      req_valid_o <= frame_end && accept;
      if (frame_end && accept) begin
        req_kind_o <= kind_i;
        req_addr_o <= base;
        req_len_o  <= (kind_i == REQ_PROG) ? data_cnt_i : '0;
      end
    end
  end

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);

  a_r11_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !$past(frame_i));

  a_r10_no_issue_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !$past(busy_i));

  a_r3_align_4k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_kind_o == REQ_ER4K) |->
      (req_addr_o[E4_W-1:0] == '0 &&
       req_addr_o[ADDR_W-1:E4_W] == $past(addr_i[ADDR_W-1:E4_W])));

  a_r4_align_32k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_kind_o == REQ_ER32K) |->
      (req_addr_o[E32_W-1:0] == '0 &&
       req_addr_o[ADDR_W-1:E32_W] == $past(addr_i[ADDR_W-1:E32_W])));

  a_r6_prog_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_kind_o == REQ_PROG) |->
      (req_len_o != '0 && req_len_o <= PAGE_BYTES));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned E4_W   = 12,
  parameter int unsigned E32_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              busy_i,
  output logic              req_valid_o,
  output logic [1:0]        req_type_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [PAGE_W:0]   req_len_o,
  input  logic [PAGE_W-1:0] buf_idx_i,
  output logic [7:0]        buf_data_o
);
  req_kind_e         kind, req_kind;
  logic [ADDR_W-1:0] addr;
  logic              hdr_done;
  logic [PAGE_W:0]   data_cnt;
  logic              wr_en;
  logic [PAGE_W-1:0] wr_off;
  logic [7:0]        wr_data;

  seq_frame_rx #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_rx (
    .clk_i, .rst_ni, .frame_i, .byte_valid_i, .byte_i,
    .kind_o(kind), .addr_o(addr), .hdr_done_o(hdr_done),
    .data_cnt_o(data_cnt), .wr_en_o(wr_en), .wr_off_o(wr_off),
    .wr_data_o(wr_data)
  );

  seq_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i, .wr_en_i(wr_en), .wr_off_i(wr_off), .wr_data_i(wr_data),
    .rd_idx_i(buf_idx_i), .rd_data_o(buf_data_o)
  );

  seq_req_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .E4_W(E4_W), .E32_W(E32_W)) u_gen (
    .clk_i, .rst_ni, .frame_i, .busy_i,
    .kind_i(kind), .addr_i(addr), .hdr_done_i(hdr_done), .data_cnt_i(data_cnt),
    .req_valid_o, .req_kind_o(req_kind), .req_addr_o, .req_len_o
  );

  assign req_type_o = req_kind;

  a_r9_no_write_unknown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (kind == REQ_PROG && frame_i));
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        busy_i = 1'b0;
  logic        req_valid_o;
  logic [1:0]  req_type_o;
  logic [16:0] req_addr_o;
  logic [8:0]  req_len_o;
  logic [7:0]  buf_idx_i = '0;
  logic [7:0]  buf_data_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_buf [256];
  bit         exp_known [256];
  logic [1:0]  last_type = '0;
  logic [16:0] last_addr = '0;
  logic [8:0]  last_len = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flash_cmd_seq dut_i (
    .clk_i, .rst_ni, .frame_i, .byte_valid_i, .byte_i, .busy_i,
    .req_valid_o, .req_type_o, .req_addr_o, .req_len_o,
    .buf_idx_i, .buf_data_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_buf(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      buf_idx_i = 8'(i);
      #1;
      if (exp_known[i] && buf_data_o !== exp_buf[i]) bad++;
    end
    chk({tag, " buffer mismatches"}, bad, 0);
  endtask

  task automatic send(input logic [7:0] b, input int gap);
    byte_i = b;
    byte_valid_i = 1'b1;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  function automatic logic [1:0] exp_type(input logic [7:0] opc);
    case (opc)
      8'h02: return 2'd1;
      8'h20: return 2'd2;
      8'h52: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic bit exp_issue(input logic [7:0] opc, input int tot, input bit bsy);
    if (bsy) return 1'b0;
    case (opc)
      8'h02: return tot >= 5;
      8'h20, 8'h52: return tot == 4;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [16:0] exp_addr(input logic [7:0] opc, input logic [23:0] a);
    logic [16:0] x = a[16:0];
    case (opc)
      8'h20: return x & 17'h1F000;
      8'h52: return x & 17'h18000;
      default: return x;
    endcase
  endfunction

  task automatic run_frame(input logic [7:0] opc, input logic [23:0] a, input int tot,
                           input bit bsy, input int maxgap, input string tag);
    bit iss;
    @(negedge clk_i);
    frame_i = 1'b1;
    busy_i = bsy;
    for (int j = 0; j < tot; j++) begin
      logic [7:0] b;
      case (j)
        0: b = opc;
        1: b = a[23:16];
        2: b = a[15:8];
        3: b = a[7:0];
        default: b = 8'($urandom);
      endcase
      if (opc == 8'h02 && j >= 4) begin
        logic [7:0] o;
        o = a[7:0] + 8'(j - 4);
        exp_buf[o] = b;
        exp_known[o] = 1'b1;
      end
      send(b, (maxgap > 0) ? int'($urandom_range(maxgap, 0)) : 0);
    end
    frame_i = 1'b0;
    @(negedge clk_i);
    iss = exp_issue(opc, tot, bsy);
    chk({tag, " R11 R5 R6 R9 R10 strobe"}, req_valid_o, iss);
    if (iss) begin
      last_type = exp_type(opc);
      last_addr = exp_addr(opc, a);
      last_len  = (opc == 8'h02) ? 9'((tot - 4 > 256) ? 256 : tot - 4) : 9'd0;
    end
    chk({tag, " R1 type"}, req_type_o, last_type);
    chk({tag, " R2 R3 R4 addr"}, req_addr_o, last_addr);
    chk({tag, " R6 R8 len"}, req_len_o, last_len);
    @(negedge clk_i);
    busy_i = 1'b0;
    chk({tag, " R11 pulse width"}, req_valid_o, 0);
    if (opc == 8'h02 || exp_type(opc) == 2'd0) chk_buf({tag, " R7 R8 R9"});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0bad5eed));
    for (int i = 0; i < 256; i++) exp_known[i] = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R13 reset valid", req_valid_o, 0);
    chk("R13 reset type", req_type_o, 0);
    chk("R13 reset addr", req_addr_o, 0);
    chk("R13 reset len", req_len_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_frame(8'h02, 24'hFE2345, 4 + 256, 1'b0, 0, "full page R2");
    run_frame(8'h02, 24'h0100F0, 4 + 300, 1'b0, 0, "long R8");
    run_frame(8'h02, 24'h0000FE, 4 + 3, 1'b0, 1, "wrap R7");
    run_frame(8'h02, 24'h000010, 4, 1'b0, 0, "no data R6");
    run_frame(8'h20, 24'h01ABCD, 4, 1'b0, 0, "er4k R3");
    run_frame(8'h52, 24'h01ABCD, 4, 1'b0, 0, "er32k R4");
    run_frame(8'h52, 24'h00FFFF, 4, 1'b0, 2, "er32k low R4");
    run_frame(8'h20, 24'h004321, 5, 1'b0, 0, "er long R5");
    run_frame(8'h52, 24'h004321, 3, 1'b0, 0, "er short R5");
    run_frame(8'h03, 24'h000000, 12, 1'b0, 0, "unknown R9");
    run_frame(8'h20, 24'h012345, 4, 1'b1, 0, "busy R10");
    run_frame(8'h02, 24'h000020, 8, 1'b1, 0, "busy prog R10");

    // R12: bytes outside a frame
    @(negedge clk_i);
    send(8'h02, 0); send(8'h00, 0); send(8'h00, 0); send(8'h00, 0);
    send(8'h77, 0); send(8'h88, 1);
    chk("R12 no strobe", req_valid_o, 0);
    chk("R12 outputs held", req_addr_o, last_addr);
    chk_buf("R12");
    run_frame(8'h20, 24'h003FFF, 4, 1'b0, 0, "after idle R12");

    for (int n = 0; n < 80; n++) begin
      logic [7:0] opc;
      int sel = int'($urandom_range(9, 0));
      int tot;
      if (sel < 4) opc = 8'h02;
      else if (sel < 6) opc = 8'h20;
      else if (sel < 8) opc = 8'h52;
      else begin
        opc = 8'($urandom);
        if (opc == 8'h02 || opc == 8'h20 || opc == 8'h52) opc = 8'hFF;
      end
      if (opc == 8'h02) tot = int'($urandom_range(300, 2));
      else if ($urandom_range(3, 0) == 0) tot = int'($urandom_range(7, 1));
      else tot = 4;
      run_frame(opc, 24'($urandom), tot, ($urandom_range(7, 0) == 0), 1, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule